// File: doc/BRIEF.md
# SMBus Register Access Target

This block is a synchronous two-wire serial target that gives a host controller byte access to a small bank of 8-bit registers. It runs on a system clock several times faster than the serial clock. Both bus lines are synchronized and noise filtered on that clock. The filtered levels feed the detection of START, repeated START and STOP conditions and of the clock edges. The block pulls the data line low through an open-drain enable to send an acknowledge or a read bit.

The device address has seven bits: a fixed upper nibble `0011` followed by three strap pins. The first byte written after the address is a command pointer that selects one register. The pointer is kept between transfers. Three transfers are supported:
- Write Byte writes the byte after the command into the selected register.
- Read Byte sends a command, then a repeated START, then reads back the register.
- Receive Byte reads the register that the stored pointer selects, as many times as the host keeps acknowledging.

Register storage sits outside the block. The block reaches it through a simple bus that carries a register address, write data, a write strobe, a read strobe and read data.

Top module: `smb_reg_target`

## Requirements
- R1: A level on SCL or SDA that lasts fewer than 3 system-clock samples has no effect. A transfer that carries such glitches completes with the same register write as a clean one.
- R2: The block acknowledges only the address byte whose upper 7 bits equal `0011` followed by `addr_pins_i[2:0]`. Bit 0 of that byte is R/W, with 1 meaning read. For any other address the block does not drive SDA and issues no register strobe until the next START.
- R3: In a write transfer, the block acknowledges the command byte and every data byte that follows it. For each data byte, `reg_we_o` pulses once with `reg_addr_o` equal to the low 2 bits of the command and `reg_wdata_o` equal to the byte. The pulse falls in the first cycle the block drives the acknowledge.
- R4: In a Read Byte transfer (address with W, command, repeated START, address with R), the block sends the selected register MSB first, starting at the SCL fall that ends the address acknowledge.
- R5: In a Receive Byte transfer (address with R and no command), the block sends the register selected by the last command written. It sends the same register again for every byte the host acknowledges. After the host's NACK it releases SDA.
- R6: Command values 4 to 255 are acknowledged. Data bytes written to them produce no write strobe, and reads from them return 0x00.
- R7: A STOP before the acknowledge clock of a data byte discards that byte. This holds even when all 8 bits have already been received: no write strobe is issued.
- R8: While `rst_ni` is low, the block releases SDA, issues no strobes and holds the command pointer at 0. The bus engine returns to idle.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: `reg_we_o` and `reg_re_o` are single-cycle pulses and never assert together. `reg_re_o` pulses once in the cycle after each byte is loaded for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low (open drain) |
| addr_pins_i | input | 3 | Strap levels for the low address bits |
| reg_addr_o | output | 2 | Register selected by the command pointer |
| reg_wdata_o | output | 8 | Write data for the register bus |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
One case forces two events together: a data byte completes its eighth bit, and a STOP arrives in the same SCL-high phase, before the falling edge that would start the acknowledge and fire the write strobe. The bench sends eight data bits with the last bit low, then raises SDA while SCL is still high. The scoreboard must see no write strobe for that byte. A later Read Byte must return the value the register held before the discarded byte.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } eng_state_e;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_CMD,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/smb_filter.sv
module smb_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      // level moves only after FILT_LEN equal samples
      if (&hist_q)       lvl_q <= 1'b1;
      else if (~|hist_q) lvl_q <= 1'b0;
    end
  end

  assign line_o = lvl_q;
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         PIN_W    = 3,
  parameter int         NUM_REGS = 4,
  parameter logic [6-PIN_W:0] ADDR_HI = 4'b0011,
  localparam int        REG_AW   = $clog2(NUM_REGS),
  localparam int        CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_pins_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_e        state_q;
  rx_kind_e          kind_q;
  logic [DATA_W-1:0] shreg_q, tx_q, cmd_q, wdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q, rw_q, oe_q, we_q, re_q;
  logic              cmd_ok, addr_hit;
  logic [DATA_W-1:0] tx_load;

  assign cmd_ok   = (cmd_q >> REG_AW) == '0;
  assign addr_hit = shreg_q[DATA_W-1:1] == {ADDR_HI, addr_pins_i};
  assign tx_load  = cmd_ok ? reg_rdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_ADDR;
      shreg_q <= '0;
      tx_q    <= '0;
      cmd_q   <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        full_q  <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_RX;
        kind_q  <= RX_ADDR;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && !full_q) begin
              shreg_q <= {shreg_q[DATA_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) full_q <= 1'b1;
            end else if (scl_fall_i && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              unique case (kind_q)
                RX_ADDR: begin
                  if (addr_hit) begin
                    rw_q    <= shreg_q[0];
                    oe_q    <= 1'b1;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                RX_CMD: begin
                  cmd_q   <= shreg_q;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
                default: begin
                  wdata_q <= shreg_q;
                  we_q    <= cmd_ok;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (kind_q == RX_ADDR && rw_q) begin
                tx_q    <= tx_load;
                re_q    <= 1'b1;
                oe_q    <= ~tx_load[DATA_W-1];
                cnt_q   <= '0;
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                kind_q  <= (kind_q == RX_ADDR) ? RX_CMD : RX_DATA;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST_BIT) begin
                oe_q    <= 1'b0;
                full_q  <= 1'b0;
                state_q <= ST_TXACK;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                tx_q  <= tx_q << 1;
                oe_q  <= ~tx_q[DATA_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) begin
              full_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (full_q) begin
                tx_q    <= tx_load;
                re_q    <= 1'b1;
                oe_q    <= ~tx_load[DATA_W-1];
                cnt_q   <= '0;
                full_q  <= 1'b0;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = cmd_q[REG_AW-1:0];
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target #(
  parameter int FILT_LEN = 3,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] addr_pins_i,
  output logic [1:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw, filt;
  logic scl_rise, scl_fall, cond_start, cond_stop;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    smb_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  smb_cond_det u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (cond_start),
    .stop_o    (cond_stop)
  );

  smb_engine #(
    .DATA_W  (8),
    .PIN_W   (3),
    .NUM_REGS(4),
    .ADDR_HI (4'b0011)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (cond_start),
    .stop_i     (cond_stop),
    .sda_i      (filt[1]),
    .addr_pins_i(addr_pins_i),
    .reg_rdata_i(reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o)
  );
endmodule

// File: rtl/smb_reg_target_chk.sv
module smb_reg_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [1:0] reg_addr_o,
  input logic       reg_we_o,
  input logic       reg_re_o
);
  // R8: held in reset means released bus, no strobes, pointer 0
  assert_reset_state_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!sda_oe_o && !reg_we_o && !reg_re_o && reg_addr_o == 2'd0));

  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  assert_we_at_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sda_oe_o);

  assert_we_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_re_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind smb_reg_target smb_reg_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .reg_addr_o(reg_addr_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o)
);

// File: tb/tb_smb_reg_target.sv
module tb_smb_reg_target;
  localparam int Q = 10;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] DEV = {4'b0011, PINS};

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, we, re;
  logic [1:0] raddr;
  logic [7:0] wdata, rdata;
  logic [7:0] regs [4];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q [$];

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = regs[raddr];

  smb_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pins_i(PINS), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  // environment register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs[0] <= 8'h11; regs[1] <= 8'h22; regs[2] <= 8'h33; regs[3] <= 8'h44;
    end else if (we) regs[raddr] <= wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && we) begin
      logic [9:0] e;
      if (exp_q.size() == 0) begin
        check(0, "R3/R6/R7 unexpected write strobe", {raddr, wdata}, 0);
      end else begin
        e = exp_q.pop_front();
        check({raddr, wdata} == e, "R3 write strobe addr/data", {raddr, wdata}, e);
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input bit b, input bit glitch);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(Q / 2);
    if (glitch) begin
      scl_m = 1'b0; wait_q(1); scl_m = 1'b1; wait_q(2);
      sda_m = ~b;   wait_q(1); sda_m = b;
    end
    wait_q(Q + Q / 2);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    b = sda_bus;  wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2 * Q);
  endtask

  task automatic send(input logic [7:0] v, input bit glitch, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) bit_out(v[i], glitch && i == 4);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(~give_ack, 1'b0);
  endtask

  task automatic write_byte(input logic [7:0] cmd, input logic [7:0] d, input bit glitch);
    bit a;
    start_c();
    send({DEV, 1'b0}, glitch, a); check(a, "R2 address ack (write)", a, 1);
    send(cmd, 1'b0, a);           check(a, "R3 command ack", a, 1);
    send(d, glitch, a);           check(a, "R3/R6 data ack", a, 1);
    stop_c();
  endtask

  task automatic read_byte(input logic [7:0] cmd, output logic [7:0] v);
    bit a;
    start_c();
    send({DEV, 1'b0}, 1'b0, a); check(a, "R4 address ack", a, 1);
    send(cmd, 1'b0, a);         check(a, "R4 command ack", a, 1);
    start_c();
    send({DEV, 1'b1}, 1'b0, a); check(a, "R4 read address ack", a, 1);
    recv(1'b0, v);
    stop_c();
  endtask

  // stop after n data bits; last bit sent low and turned into STOP
  task automatic data_then_stop(input logic [7:0] cmd, input logic [7:0] v, input int n);
    bit a;
    start_c();
    send({DEV, 1'b0}, 1'b0, a);
    send(cmd, 1'b0, a);
    for (int i = 7; i > 8 - n; i--) bit_out(v[i], 1'b0);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2 * Q);
  endtask

  initial begin
    logic [7:0] v;
    bit a;
    rst_n = 1'b0;
    wait_q(5);
    check(sda_oe == 0, "R8 sda released in reset", sda_oe, 0);
    check(raddr == 0, "R8 pointer 0 in reset", raddr, 0);
    check(!we && !re, "R8 no strobes in reset", {we, re}, 0);
    rst_n = 1'b1;
    wait_q(5);

    // R3 write byte
    exp_q.push_back({2'd1, 8'h5A});
    write_byte(8'h01, 8'h5A, 1'b0);
    // R1 glitched transfer
    exp_q.push_back({2'd2, 8'h3C});
    write_byte(8'h02, 8'h3C, 1'b1);
    read_byte(8'h02, v);
    check(v == 8'h3C, "R1 glitched write landed", v, 8'h3C);

    // R4 read byte
    read_byte(8'h01, v);
    check(v == 8'h5A, "R4 read byte data", v, 8'h5A);

    // R5 receive byte, pointer is 1 now
    start_c();
    send({DEV, 1'b1}, 1'b0, a); check(a, "R5 address ack", a, 1);
    recv(1'b1, v); check(v == 8'h5A, "R5 receive byte 1", v, 8'h5A);
    recv(1'b1, v); check(v == 8'h5A, "R5 receive byte 2", v, 8'h5A);
    recv(1'b0, v); check(v == 8'h5A, "R5 receive byte 3", v, 8'h5A);
    wait_q(2);
    check(sda_oe == 0, "R5 sda released after nack", sda_oe, 0);
    stop_c();

    // R2 wrong addresses: no ack, no strobe
    start_c();
    send({DEV ^ 7'h01, 1'b0}, 1'b0, a); check(!a, "R2 low bit mismatch nack", a, 0);
    send(8'h00, 1'b0, a);               check(!a, "R2 no ack after mismatch", a, 0);
    send(8'hEE, 1'b0, a);
    stop_c();
    start_c();
    send({7'h5D, 1'b0}, 1'b0, a); check(!a, "R2 high nibble mismatch nack", a, 0);
    stop_c();
    read_byte(8'h00, v);
    check(v == 8'h11, "R2 register untouched by foreign address", v, 8'h11);

    // R6 out-of-range command
    write_byte(8'h05, 8'h77, 1'b0);
    read_byte(8'h05, v);
    check(v == 8'h00, "R6 read of command 5 is zero", v, 0);
    read_byte(8'h01, v);
    check(v == 8'h5A, "R6 reg1 unchanged after command 5 write", v, 8'h5A);

    // R7 stop mid byte and at eighth bit
    data_then_stop(8'h00, 8'hF0, 5);
    data_then_stop(8'h00, 8'hA6, 8);
    read_byte(8'h00, v);
    check(v == 8'h11, "R7 discarded bytes left reg0", v, 8'h11);

    // R3 several data bytes to one register
    exp_q.push_back({2'd3, 8'hA5});
    exp_q.push_back({2'd3, 8'h5B});
    start_c();
    send({DEV, 1'b0}, 1'b0, a);
    send(8'h03, 1'b0, a);
    send(8'hA5, 1'b0, a); check(a, "R3 first data ack", a, 1);
    send(8'h5B, 1'b0, a); check(a, "R3 second data ack", a, 1);
    stop_c();
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    // R8 reset restores pointer 0
    check(raddr == 2'd3, "R8 pointer before reset", raddr, 3);
    rst_n = 1'b0; wait_q(3);
    check(raddr == 0, "R8 pointer cleared by reset", raddr, 0);
    rst_n = 1'b1; wait_q(5);
    start_c();
    send({DEV, 1'b1}, 1'b0, a);
    recv(1'b0, v);
    stop_c();
    check(v == 8'h11, "R8 receive byte after reset uses reg0", v, 8'h11);

    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule